// File: doc/BRIEF.md
# Address-Mark Wait and Sync Matcher

This block carries out the wait step of a disk format instruction. An instruction is launched with a one-cycle `start` pulse. The pulse loads four wait selectors, a timeout limit and the expected sync byte. The block then waits for one of two things:

- an address-mark detect on `amark_det`, which leads into a sync search, or
- a rising edge on the index or sector input.

When the sync search finds the programmed byte in the serial read stream, the block marks the byte boundary and signals the checksum unit to begin with that byte. If a data-mark wait runs past its byte budget, or the sync search uses up its bit window, the block reports a sync error. It also raises retry and halt requests according to their enables.

The surrounding sequencer reads `busy` and `done` to move on to the next instruction. It can abort any wait with `kill`.

Top module: `amw_top`

## Requirements
- R1: After reset, `busy`, `done`, `byte_sync`, `csum_start`, `sync_err`, `retry_req` and `halt_req` are 0, and `bit_phase` is 0.
- R2: A start with `sel_imark`=1 waits on `amark_det` with no byte limit. Any number of `byte_stb` pulses raises no sync error, and `busy` stays 1.
- R3: A start with `sel_dmark`=1 loads `dmark_limit`=N. While the block waits for the mark with `amark_det` low, the first N `byte_stb` pulses pass without error. The (N+1)th pulse gives a one-cycle `sync_err` in the following cycle, and the block goes idle.
- R4: A cycle in the mark wait with `amark_det`=1 starts the sync search in the next cycle, with an empty 8-bit history. Each `bit_stb` shifts `rd_bit` in at bit 0, so the first bit received ends up at bit 7 (MSB first). A match requires at least 8 bits received since the search began. One cycle after the matching bit strobe, `byte_sync`, `csum_start` and `done` pulse together, `bit_phase` is 0, and `busy` is 0.
- R5: During the search, only bit strobes that come while `amark_det`=1 count against a 16-bit window. The 16th such bit without a match gives `sync_err` one cycle later. `done` and `sync_err` are never 1 together.
- R6: `retry_req` equals `sync_err & retry_en`, and `halt_req` equals `sync_err & fail_en`. All three are registered in the same cycle.
- R7: A start with `sel_index` and/or `sel_sector` (and neither mark selector) waits for a rising edge of a selected input, after a two-flop synchronizer. `done` pulses once, three clock edges after the input rises. Rising edges on an unselected input are ignored. With both selected, whichever input rises first ends the wait.
- R8: `kill` has priority over every state. One cycle later `busy` is 0, and `sync_err`, `done`, `retry_req` and `halt_req` are 0.
- R9: `bit_phase` counts `bit_strobe` pulses modulo 8 in every state. A sync match sets it to 0.
- R10: A start pulse while `busy`=1 is ignored. The pending wait and its configuration are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a wait; configuration sampled here |
| sel_dmark | input | 1 | Wait for data mark with byte timeout |
| sel_imark | input | 1 | Wait for ID mark, no timeout |
| sel_index | input | 1 | Wait for index edge |
| sel_sector | input | 1 | Wait for sector edge |
| dmark_limit | input | 7 | Byte-time budget for the data-mark wait |
| sync_pat | input | 8 | Expected sync byte |
| rd_bit | input | 1 | Serial read data |
| bit_stb | input | 1 | Qualifies `rd_bit`, one per bit time |
| byte_stb | input | 1 | One pulse per byte time |
| amark_det | input | 1 | Address-mark detect |
| index_in | input | 1 | Asynchronous index input |
| sector_in | input | 1 | Asynchronous sector input |
| kill | input | 1 | Abort any wait |
| retry_en | input | 1 | Request retry on sync error |
| fail_en | input | 1 | Request halt on sync error |
| busy | output | 1 | A wait is in progress |
| done | output | 1 | Wait satisfied (pulse) |
| byte_sync | output | 1 | Byte boundary found (pulse) |
| csum_start | output | 1 | Start checksum, sync byte included (pulse) |
| bit_phase | output | 3 | Bit position within the byte |
| sync_err | output | 1 | Timeout or window exhausted (pulse) |
| retry_req | output | 1 | Retry request (pulse) |
| halt_req | output | 1 | Halt request (pulse) |

## Verification
A wrong history register or a miscounted fill level shows up at the ports in the cycle after the eighth bit: `byte_sync` comes early, comes late or never comes. A window counter that also counts bits taken while the mark detect is low makes `sync_err` appear before the sixteenth counted bit. An off-by-one in the byte timer moves `sync_err` by exactly one byte strobe. A stale state after `kill` shows within one cycle as `busy` still high. Each of these is visible no later than the strobe that exposes it, and the sweeps over every sync byte value and a range of timeout limits place the expected edge exactly.

// File: rtl/amw_pkg.sv
package amw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MARK  = 2'd1,
    ST_SYNC  = 2'd2,
    ST_EVENT = 2'd3
  } amw_state_e;
endpackage

// File: rtl/amw_edge_det.sv
module amw_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/amw_byte_timer.sv
module amw_byte_timer #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] limit,
  input  logic         en,
  input  logic         byte_stb,
  output logic         expire
);
  logic [W-1:0] cnt;

  function automatic logic budget_spent(input logic [W-1:0] c);
    return c == '0;
  endfunction

  assign expire = en & byte_stb & budget_spent(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   cnt <= '0;
    else if (load)                                cnt <= limit;
    else if (en && byte_stb && !budget_spent(cnt)) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/amw_sync_search.sv
module amw_sync_search #(
  parameter int PAT_W    = 8,
  parameter int WIN_BITS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             en,
  input  logic             bit_stb,
  input  logic             bit_in,
  input  logic             am_det,
  input  logic [PAT_W-1:0] pat,
  output logic             hit,
  output logic             exhaust
);
  localparam int FILL_W = $clog2(PAT_W + 1);
  localparam int WIN_W  = $clog2(WIN_BITS + 1);

  logic [PAT_W-1:0]  hist_q, hist_nx;
  logic [FILL_W-1:0] fill_q;
  logic [WIN_W-1:0]  win_q;
  logic              full_nx;

  function automatic logic [PAT_W-1:0] shift_msb_first(input logic [PAT_W-1:0] cur,
                                                       input logic b);
    return {cur[PAT_W-2:0], b};
  endfunction

  assign hist_nx = shift_msb_first(hist_q, bit_in);
  assign full_nx = fill_q >= FILL_W'(PAT_W - 1);
  assign hit     = en & bit_stb & full_nx & (hist_nx == pat);
  assign exhaust = en & bit_stb & am_det & ~hit & (win_q == WIN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      fill_q <= '0;
      win_q  <= WIN_W'(WIN_BITS);
    end else if (clear) begin
      hist_q <= '0;
      fill_q <= '0;
      win_q  <= WIN_W'(WIN_BITS);
    end else if (en && bit_stb) begin
      hist_q <= hist_nx;
      if (fill_q != FILL_W'(PAT_W)) fill_q <= fill_q + 1'b1;
      if (am_det && win_q != '0)    win_q  <= win_q - 1'b1;
    end
  end
endmodule

// File: rtl/amw_top.sv
module amw_top
  import amw_pkg::*;
#(
  parameter int PAT_W       = 8,
  parameter int WIN_BITS    = 16,
  parameter int TMO_W       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     sel_dmark,
  input  logic                     sel_imark,
  input  logic                     sel_index,
  input  logic                     sel_sector,
  input  logic [TMO_W-1:0]         dmark_limit,
  input  logic [PAT_W-1:0]         sync_pat,
  input  logic                     rd_bit,
  input  logic                     bit_stb,
  input  logic                     byte_stb,
  input  logic                     amark_det,
  input  logic                     index_in,
  input  logic                     sector_in,
  input  logic                     kill,
  input  logic                     retry_en,
  input  logic                     fail_en,
  output logic                     busy,
  output logic                     done,
  output logic                     byte_sync,
  output logic                     csum_start,
  output logic [$clog2(PAT_W)-1:0] bit_phase,
  output logic                     sync_err,
  output logic                     retry_req,
  output logic                     halt_req
);
  localparam int PH_W = $clog2(PAT_W);

  amw_state_e       state_q, state_nx;
  logic             dmark_q, want_idx_q, want_sec_q;
  logic [PAT_W-1:0] pat_q;

  // named internal events
  logic take_start, mark_wait, enter_sync, mark_tmo, tmr_expire;
  logic sync_hit, sync_exhaust, idx_rise, sec_rise, evt_hit, err_now;

  assign mark_wait  = (state_q == ST_MARK) & ~kill;
  assign take_start = start & ~kill & (state_q == ST_IDLE) &
                      (sel_dmark | sel_imark | sel_index | sel_sector);
  assign enter_sync = mark_wait & amark_det;
  assign mark_tmo   = tmr_expire;
  assign evt_hit    = (state_q == ST_EVENT) & ~kill &
                      ((want_idx_q & idx_rise) | (want_sec_q & sec_rise));
  assign err_now    = mark_tmo | sync_exhaust;

  amw_byte_timer #(.W(TMO_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(take_start), .limit(dmark_limit),
    .en(mark_wait & dmark_q & ~amark_det), .byte_stb(byte_stb), .expire(tmr_expire)
  );

  amw_sync_search #(.PAT_W(PAT_W), .WIN_BITS(WIN_BITS)) u_srch (
    .clk(clk), .rst_n(rst_n), .clear(enter_sync),
    .en((state_q == ST_SYNC) & ~kill), .bit_stb(bit_stb), .bit_in(rd_bit),
    .am_det(amark_det), .pat(pat_q), .hit(sync_hit), .exhaust(sync_exhaust)
  );

  amw_edge_det #(.STAGES(SYNC_STAGES)) u_idx (
    .clk(clk), .rst_n(rst_n), .async_in(index_in), .rise(idx_rise)
  );
  amw_edge_det #(.STAGES(SYNC_STAGES)) u_sec (
    .clk(clk), .rst_n(rst_n), .async_in(sector_in), .rise(sec_rise)
  );

  always_comb begin
    state_nx = state_q;
    if (kill) begin
      state_nx = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE:  if (take_start)
                    state_nx = (sel_dmark | sel_imark) ? ST_MARK : ST_EVENT;
        ST_MARK:  if (enter_sync)    state_nx = ST_SYNC;
                  else if (mark_tmo) state_nx = ST_IDLE;
        ST_SYNC:  if (sync_hit | sync_exhaust) state_nx = ST_IDLE;
        ST_EVENT: if (evt_hit)       state_nx = ST_IDLE;
        default:  state_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      dmark_q    <= 1'b0;
      want_idx_q <= 1'b0;
      want_sec_q <= 1'b0;
      pat_q      <= '0;
      done       <= 1'b0;
      byte_sync  <= 1'b0;
      csum_start <= 1'b0;
      sync_err   <= 1'b0;
      retry_req  <= 1'b0;
      halt_req   <= 1'b0;
      bit_phase  <= '0;
    end else begin
      state_q <= state_nx;
      if (take_start) begin
        dmark_q    <= sel_dmark;
        want_idx_q <= sel_index;
        want_sec_q <= sel_sector;
        pat_q      <= sync_pat;
      end
      done       <= sync_hit | evt_hit;
      byte_sync  <= sync_hit;
      csum_start <= sync_hit;
      sync_err   <= err_now;
      retry_req  <= err_now & retry_en;
      halt_req   <= err_now & fail_en;
      if (sync_hit)     bit_phase <= '0;
      else if (bit_stb) bit_phase <= bit_phase + 1'b1;
    end
  end

  assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/amw_checker.sv
module amw_checker #(
  parameter int PH_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            kill,
  input logic            bit_stb,
  input logic            busy,
  input logic            done,
  input logic            byte_sync,
  input logic            csum_start,
  input logic [PH_W-1:0] bit_phase,
  input logic            sync_err,
  input logic            retry_req,
  input logic            halt_req,
  input logic            sync_hit
);
  p_kill_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (!busy && !sync_err && !done && !retry_req && !halt_req));

  p_retry_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    retry_req |-> sync_err);

  p_halt_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> sync_err);

  p_sync_mark_r4: assert property (@(posedge clk) disable iff (!rst_n)
    byte_sync |-> (csum_start && done && bit_phase == '0));

  p_hit_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_hit |=> !busy);

  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, sync_err}));

  p_phase_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bit_stb) && !byte_sync) |-> bit_phase == PH_W'($past(bit_phase) + 1'b1));
endmodule

bind amw_top amw_checker #(.PH_W($clog2(PAT_W))) u_chk (
  .clk(clk), .rst_n(rst_n), .kill(kill), .bit_stb(bit_stb), .busy(busy),
  .done(done), .byte_sync(byte_sync), .csum_start(csum_start),
  .bit_phase(bit_phase), .sync_err(sync_err), .retry_req(retry_req),
  .halt_req(halt_req), .sync_hit(sync_hit)
);

// File: tb/sim_amw_top.sv
module sim_amw_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, sel_dmark = 0, sel_imark = 0, sel_index = 0, sel_sector = 0;
  logic [6:0] dmark_limit = '0;
  logic [7:0] sync_pat = '0;
  logic rd_bit = 0, bit_stb = 0, byte_stb = 0, amark_det = 0;
  logic index_in = 0, sector_in = 0, kill = 0, retry_en = 0, fail_en = 0;
  logic busy, done, byte_sync, csum_start, sync_err, retry_req, halt_req;
  logic [2:0] bit_phase;

  int total = 0, bad = 0, cycles = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  amw_top u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .sel_dmark(sel_dmark),
    .sel_imark(sel_imark), .sel_index(sel_index), .sel_sector(sel_sector),
    .dmark_limit(dmark_limit), .sync_pat(sync_pat), .rd_bit(rd_bit),
    .bit_stb(bit_stb), .byte_stb(byte_stb), .amark_det(amark_det),
    .index_in(index_in), .sector_in(sector_in), .kill(kill),
    .retry_en(retry_en), .fail_en(fail_en), .busy(busy), .done(done),
    .byte_sync(byte_sync), .csum_start(csum_start), .bit_phase(bit_phase),
    .sync_err(sync_err), .retry_req(retry_req), .halt_req(halt_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
    cycles++;
  endtask

  task automatic launch(input logic dm, im, ix, sc, input logic [6:0] lim, input logic [7:0] pat);
    sel_dmark = dm; sel_imark = im; sel_index = ix; sel_sector = sc;
    dmark_limit = lim; sync_pat = pat; start = 1;
    cyc();
    start = 0; sel_dmark = 0; sel_imark = 0; sel_index = 0; sel_sector = 0;
    dmark_limit = '0; sync_pat = '0;
  endtask

  task automatic send_bit(input logic b, input logic am);
    rd_bit = b; amark_det = am; bit_stb = 1;
    cyc();
    bit_stb = 0;
  endtask

  task automatic mark_seen();
    amark_det = 1;
    cyc();
  endtask

  task automatic do_kill();
    kill = 1;
    cyc();
    kill = 0;
  endtask

  task automatic settle_events();
    index_in = 0; sector_in = 0; amark_det = 0;
    repeat (4) cyc();
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      if (cycles > 150000 && !finished) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=0", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int hits, errs;
    logic [7:0] p;
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 sync_err", sync_err, 0);
    chk("R1 req", {retry_req, halt_req, byte_sync, csum_start}, 0);
    chk("R1 bit_phase", bit_phase, 0);

    // R9 phase counts modulo 8 in idle
    for (int i = 0; i < 10; i++) send_bit(0, 0);
    chk("R9 phase after 10 bits", bit_phase, 2);

    // R4 exhaustive sync byte sweep
    for (int v = 0; v < 256; v++) begin
      p = 8'(v);
      launch(0, 1, 0, 0, 7'd0, p);
      mark_seen();
      hits = 0;
      for (int i = 0; i < 7; i++) begin
        send_bit(p[7-i], 1);
        hits += int'(done);
      end
      chk("R4 no early match", hits, 0);
      send_bit(p[0], 1);
      chk("R4 byte_sync", byte_sync, 1);
      chk("R4 csum_start", csum_start, 1);
      chk("R4 done", done, 1);
      chk("R4 phase zero", bit_phase, 0);
      chk("R4 idle after match", busy, 0);
      amark_det = 0;
      cyc();
    end
    // R9 phase continues after match
    for (int i = 0; i < 3; i++) send_bit(1, 0);
    chk("R9 phase after match+3", bit_phase, 3);

    // R5 window: bits with mark detect low do not count; 16th counted bit errors
    for (int combo = 0; combo < 4; combo++) begin
      retry_en = combo[0]; fail_en = combo[1];
      launch(0, 1, 0, 0, 7'd0, 8'hFF);
      mark_seen();
      for (int i = 0; i < 5; i++) send_bit(0, 0);
      errs = 0;
      for (int i = 0; i < 15; i++) begin
        send_bit(0, 1);
        errs += int'(sync_err);
      end
      chk("R5 no early window error", errs, 0);
      chk("R5 still searching", busy, 1);
      send_bit(0, 1);
      chk("R5 error at 16th counted bit", sync_err, 1);
      chk("R6 retry_req", retry_req, combo[0]);
      chk("R6 halt_req", halt_req, combo[1]);
      chk("R5 done low on error", done, 0);
      chk("R5 idle after error", busy, 0);
      amark_det = 0;
      cyc();
      chk("R6 pulse only", {sync_err, retry_req, halt_req}, 0);
    end
    retry_en = 0; fail_en = 0;

    // R5 match after many uncounted bits
    launch(0, 1, 0, 0, 7'd0, 8'hA5);
    mark_seen();
    for (int i = 0; i < 12; i++) send_bit(0, 0);
    for (int i = 0; i < 7; i++) send_bit(p[7-i] ^ p[7-i] ^ ((8'hA5 >> (7-i)) & 1), 1);
    send_bit(1, 1);
    chk("R5 match beyond 16 raw bits", byte_sync, 1);
    chk("R5 no error", sync_err, 0);
    amark_det = 0;
    cyc();

    // R3 data-mark timeout sweep
    for (int n = 0; n < 14; n++) begin
      int lim = (n == 13) ? 127 : n;
      retry_en = n[0]; fail_en = n[1];
      launch(1, 0, 0, 0, 7'(lim), 8'h3C);
      errs = 0;
      for (int i = 0; i < lim; i++) begin
        byte_stb = 1; cyc(); byte_stb = 0;
        errs += int'(sync_err);
      end
      chk("R3 no error within budget", errs, 0);
      chk("R3 still waiting", busy, 1);
      byte_stb = 1; cyc(); byte_stb = 0;
      chk("R3 error on budget+1", sync_err, 1);
      chk("R6 retry on timeout", retry_req, n[0]);
      chk("R6 halt on timeout", halt_req, n[1]);
      chk("R3 idle after timeout", busy, 0);
      cyc();
    end
    retry_en = 1; fail_en = 1;

    // R2 ID-mark wait ignores byte strobes
    launch(0, 1, 0, 0, 7'd0, 8'h11);
    errs = 0;
    for (int i = 0; i < 300; i++) begin
      byte_stb = 1; cyc(); byte_stb = 0;
      errs += int'(sync_err);
    end
    chk("R2 no timeout", errs, 0);
    chk("R2 still busy", busy, 1);

    // R8 kill in mark wait
    do_kill();
    chk("R8 kill in mark wait busy", busy, 0);
    chk("R8 kill no error", sync_err, 0);

    // R8 kill in sync search, at the bit that would exhaust window
    launch(0, 1, 0, 0, 7'd0, 8'hFF);
    mark_seen();
    for (int i = 0; i < 15; i++) send_bit(0, 1);
    kill = 1; bit_stb = 1; rd_bit = 0;
    cyc();
    kill = 0; bit_stb = 0; amark_det = 0;
    chk("R8 kill beats window error", sync_err, 0);
    chk("R8 kill in search busy", busy, 0);
    chk("R8 kill no retry/halt", {retry_req, halt_req}, 0);

    // R8 kill beats the mark in the same cycle
    launch(0, 1, 0, 0, 7'd0, 8'hFF);
    kill = 1; amark_det = 1;
    cyc();
    kill = 0; amark_det = 0;
    chk("R8 kill with mark", busy, 0);

    // R7 index only: sector ignored
    launch(0, 0, 1, 0, 7'd0, 8'h00);
    sector_in = 1;
    hits = 0;
    for (int i = 0; i < 6; i++) begin cyc(); hits += int'(done); end
    chk("R7 sector ignored", hits, 0);
    chk("R7 still busy", busy, 1);
    index_in = 1;
    cyc(); cyc();
    chk("R7 not before third edge", done, 0);
    cyc();
    chk("R7 done on third edge", done, 1);
    cyc();
    chk("R7 single pulse", {done, busy}, 0);
    settle_events();

    // R7 sector only: index ignored
    launch(0, 0, 0, 1, 7'd0, 8'h00);
    index_in = 1;
    hits = 0;
    for (int i = 0; i < 6; i++) begin cyc(); hits += int'(done); end
    chk("R7 index ignored", hits, 0);
    sector_in = 1;
    hits = 0;
    for (int i = 0; i < 5; i++) begin cyc(); hits += int'(done); end
    chk("R7 sector ends wait", hits, 1);
    settle_events();

    // R7 both selected: first event wins
    for (int w = 0; w < 2; w++) begin
      launch(0, 0, 1, 1, 7'd0, 8'h00);
      if (w == 0) index_in = 1; else sector_in = 1;
      hits = 0;
      for (int i = 0; i < 5; i++) begin cyc(); hits += int'(done); end
      chk("R7 either event", hits, 1);
      chk("R7 idle after event", busy, 0);
      settle_events();
    end

    // R8 kill in event wait
    launch(0, 0, 1, 1, 7'd0, 8'h00);
    do_kill();
    chk("R8 kill in event wait", busy, 0);
    index_in = 1;
    hits = 0;
    for (int i = 0; i < 5; i++) begin cyc(); hits += int'(done); end
    chk("R8 no done after kill", hits, 0);
    settle_events();

    // R10 start while busy ignored
    launch(0, 1, 0, 0, 7'd0, 8'hC3);
    launch(0, 0, 1, 0, 7'd0, 8'h00);
    index_in = 1;
    hits = 0;
    for (int i = 0; i < 6; i++) begin cyc(); hits += int'(done); end
    chk("R10 second start ignored", hits, 0);
    chk("R10 still busy", busy, 1);
    mark_seen();
    for (int i = 0; i < 8; i++) send_bit(((8'hC3 >> (7-i)) & 1) != 0, 1);
    chk("R10 original pattern kept", byte_sync, 1);
    settle_events();

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule